// File: doc/BRIEF.md
# Serial-Programmed Wiper Register with Nonvolatile Restore

This block is the digital control core of a 256-position digital potentiometer. A host talks to it over a three-wire serial port: an active-low select, a serial clock, and one data line. The data line is modelled as three signals: an input, an output and an output enable. The port, clock and data are brought into the system clock domain through two-flop synchronisers. Edges of the serial clock are found in that domain. Each frame holds an 8-bit command and then an 8-bit data byte, sent most significant bit first. A frame takes effect when the select line goes high.

An 8-bit wiper latch drives a decoder with one output per tap, and exactly one output is active. A behavioural nonvolatile byte holds the last saved wiper code. Reset loads the latch from that byte. A byte that was never written reads as midscale. A save command copies the latch into the byte and then holds a busy flag for a fixed programming time, counted in system clocks. While busy, write and save frames have no effect. A read frame still works, so the host can poll the busy flag.

Top module: `spi_wiper_core`

## Requirements
- R1: While reset is held, the wiper latch loads from the nonvolatile byte, which holds 0x80 until the first save. `tap_sel` always has exactly one bit set, and that bit sits at the index equal to the latch value.
- R2: A frame of exactly 16 bits with command 0x01 sets the latch to the data byte. Bits are sampled on serial clock rising edges, command MSB first, then data MSB first. The latch changes only after the select line rises.
- R3: A frame with any bit count other than 16 leaves the latch unchanged, whatever its command. Short (15-bit) and long (17-bit) frames are both covered.
- R4: A 16-bit frame whose command is not 0x01, 0x02 or 0x03 has no effect on the latch.
- R5: A 16-bit frame with command 0x02 copies the latch into the nonvolatile byte. It then drives `nv_busy` high for exactly BUSY_CYCLES system clock cycles.
- R6: While `nv_busy` is high, write and save frames are ignored.
- R7: Read frames use command 0x03. After the 8th rising edge of the frame, `spi_sdo_en` goes high and `spi_sdo` presents a 9-bit reply, one bit per following rising edge. The first bit is the busy flag, then the latch MSB first. `spi_sdo_en` goes low once the select line is high. Reads also work while busy.
- R8: A reset after a save restores the saved code. Reset does not clear the nonvolatile byte.
- R9: Serial clock edges while the select line is high are not counted and do not change the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; while low, restores the latch from the nonvolatile byte |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host during a read |
| spi_sdo_en | output | 1 | Output enable for the shared data pin |
| tap_sel | output | 256 | One-hot tap select |
| nv_busy | output | 1 | Nonvolatile programming in progress |

## Verification
The bench sends frames of 15 and 17 bits that carry a valid write command. A design that latched on any eighth or sixteenth edge, rather than checking the final count, would move the wiper on these. During a busy window it issues a write and a read. The write catches a design that only blocks saves. The read catches one that also blocks status polling. It measures the busy width to the exact cycle and pulses reset twice, with a different value saved before each pulse. A nonvolatile byte cleared by reset, or a latch that always restores midscale, shows up as the wrong tap. Clock toggling with the select line high checks that stray edges are not counted into the next frame.

// File: rtl/spi_wiper_core.sv
module spi_wiper_core #(
  parameter int CODE_W = 8,
  parameter int BUSY_CYCLES = 2_500_000,
  parameter logic [CODE_W-1:0] NV_BLANK = {1'b1, {(CODE_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_en,
  output logic [(1<<CODE_W)-1:0] tap_sel,
  output logic              nv_busy
);
  localparam int TAPS       = 1 << CODE_W;
  localparam int CMD_W      = 8;
  localparam int FRAME_BITS = CMD_W + CODE_W;
  localparam int CNT_MAX    = FRAME_BITS + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int BW         = $clog2(BUSY_CYCLES + 1);
  localparam logic [CMD_W-1:0] OP_WRITE = 8'h01;
  localparam logic [CMD_W-1:0] OP_SAVE  = 8'h02;
  localparam logic [CMD_W-1:0] OP_READ  = 8'h03;

  logic [2:0] sclk_q, cs_q;
  logic [1:0] sdi_q;
  logic [FRAME_BITS-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic [CODE_W:0] out_sh;
  logic [CODE_W-1:0] wiper;
  logic [CODE_W-1:0] nv_cell = NV_BLANK;
  logic [BW-1:0] bcnt;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire cs_active = ~cs_q[1];
  wire frame_end = cs_q[1] & ~cs_q[2];
  wire bit_in    = sdi_q[1];
  wire [CMD_W-1:0] cmd_now = {sh[CMD_W-2:0], bit_in};
  wire [CMD_W-1:0] fr_cmd  = sh[FRAME_BITS-1 -: CMD_W];
  wire fr_ok = frame_end && (cnt == CNT_W'(FRAME_BITS)) && !nv_busy;

  assign nv_busy = (bcnt != '0);
  assign spi_sdo = out_sh[CODE_W];
  assign tap_sel = TAPS'(1) << wiper;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 3'b000;
      cs_q   <= 3'b111;
      sdi_q  <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      sdi_q  <= {sdi_q[0], spi_sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      cnt <= '0;
      out_sh <= '0;
      spi_sdo_en <= 1'b0;
    end else if (!cs_active) begin
      cnt <= '0;
      spi_sdo_en <= 1'b0;
    end else if (sclk_rise) begin
      sh <= {sh[FRAME_BITS-2:0], bit_in};
      if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(CMD_W-1) && cmd_now == OP_READ) begin
        spi_sdo_en <= 1'b1;
        out_sh <= {nv_busy, wiper};
      end else if (spi_sdo_en) begin
        out_sh <= {out_sh[CODE_W-1:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wiper <= nv_cell;
      bcnt  <= '0;
    end else begin
      if (fr_ok && fr_cmd == OP_WRITE) wiper <= sh[CODE_W-1:0];
      if (fr_ok && fr_cmd == OP_SAVE) bcnt <= BW'(BUSY_CYCLES);
      else if (nv_busy) bcnt <= bcnt - BW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fr_ok && fr_cmd == OP_SAVE) nv_cell <= wiper;
  end

  a_r1_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);
  a_r2_latch_waits_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(wiper));
  a_r6_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && frame_end) |=> ($stable(wiper) && $stable(nv_cell)));
  a_r5_save_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> (nv_cell == $past(wiper)));
  a_r7_sdo_released: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q[2] |-> !spi_sdo_en);
endmodule

// File: tb/spi_wiper_core_test.sv
module spi_wiper_core_test;
  localparam int BUSY = 400;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_en, busy;
  logic [255:0] tap;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  spi_wiper_core #(.CODE_W(8), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_en(sdo_en), .tap_sel(tap), .nv_busy(busy));

  always #4 clk = ~clk;

  // {bit count, frame bits right-aligned, expected code after}
  localparam logic [36:0] VEC [0:7] = '{
    {5'd16, 24'h00013C, 8'h3C},   // R2
    {5'd16, 24'h0001FF, 8'hFF},   // R2
    {5'd16, 24'h000100, 8'h00},   // R2
    {5'd16, 24'h000755, 8'h00},   // R4
    {5'd15, 24'h0000D5, 8'h00},   // R3 short
    {5'd17, 24'h000354, 8'h00},   // R3 long
    {5'd16, 24'h0001A5, 8'hA5},   // R2
    {5'd16, 24'h000011, 8'hA5}    // R4
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_tap(input string tag, input logic [7:0] exp);
    int idx = -1;
    for (int i = 0; i < 256; i++) if (tap[i]) idx = i;
    chk(tap === (256'd1 << exp), tag, idx, exp);
  endtask

  task automatic frame(input logic [23:0] bits, input int n, input int post);
    cs_n = 1'b0; tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i]; tick(3); sclk = 1'b1; tick(3); sclk = 1'b0;
    end
    tick(3); cs_n = 1'b1; tick(post);
  endtask

  task automatic read_back(output logic [8:0] r, output logic oe_ok);
    logic [7:0] op = 8'h03;
    oe_ok = 1'b1;
    cs_n = 1'b0; tick(4);
    for (int k = 0; k < 17; k++) begin
      sdi = (k < 8) ? op[7-k] : 1'b0;
      tick(3);
      if (k >= 8) begin r[16-k] = sdo; oe_ok &= sdo_en; end
      sclk = 1'b1; tick(3); sclk = 1'b0;
    end
    tick(3); cs_n = 1'b1; tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] r;
    logic oe_ok;
    int n;
    tick(5); rst_n = 1'b1; tick(3);
    chk_tap("R1 blank restore midscale", 8'h80);
    chk(busy === 1'b0, "R5 idle busy after reset", busy, 0);
    chk(sdo_en === 1'b0, "R7 sdo_en idle after reset", sdo_en, 0);

    for (int v = 0; v < 8; v++) begin
      frame(VEC[v][31:8], int'(VEC[v][36:32]), 8);
      chk_tap($sformatf("R2/R3/R4 vector %0d", v), VEC[v][7:0]);
    end

    // R9: clock activity with select high
    for (int i = 0; i < 16; i++) begin
      sdi = ~sdi; tick(3); sclk = 1'b1; tick(3); sclk = 1'b0;
    end
    tick(8);
    frame(24'h000100, 16, 8);
    chk_tap("R9 stray clocks then write 0x00", 8'h00);
    frame(24'h0001A5, 16, 8);

    read_back(r, oe_ok);
    chk(r === 9'h0A5, "R7 read idle", r, 9'h0A5);
    chk(oe_ok === 1'b1, "R7 sdo_en during reply", oe_ok, 1);
    chk(sdo_en === 1'b0, "R7 sdo_en after frame", sdo_en, 0);

    frame(24'h000200, 16, 8);
    chk(busy === 1'b1, "R5 busy after save", busy, 1);
    read_back(r, oe_ok);
    chk(r === 9'h1A5, "R7 read while busy", r, 9'h1A5);
    frame(24'h000110, 16, 8);
    chk_tap("R6 write ignored while busy", 8'hA5);
    chk(busy === 1'b1, "R6 still busy", busy, 1);
    while (busy) tick(1);
    frame(24'h000110, 16, 8);
    chk_tap("R2 write after busy", 8'h10);

    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk_tap("R8 restore first save", 8'hA5);

    frame(24'h000122, 16, 8);
    frame(24'h000200, 16, 0);
    while (!busy) tick(1);
    n = 0;
    while (busy) begin n++; tick(1); end
    chk(n == BUSY, "R5 busy width", n, BUSY);
    frame(24'h000133, 16, 8);
    chk_tap("R2 write after second save", 8'h33);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk_tap("R8 restore second save", 8'h22);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule